// File: doc/BRIEF.md
# Single-Channel DMA Engine with Dual and Single Addressing

This block is one DMA channel that moves data over a simple external bus. The bus has an address, a read strobe, a write strobe, a data path and an acknowledge strobe. Software first loads a source address, a destination address, a unit count and a control word, and then sets the start bit. The channel then runs without further help. It raises an end-of-transfer pulse during the last unit's bus cycle and sets a done flag when it finishes.

The channel has two modes. In dual mode, each unit is a read cycle at the source address, followed by a write cycle at the destination address. The read data is held inside the channel between the two cycles. In single mode, the memory side is selected by the address and the peripheral side by the acknowledge strobe, so each unit takes exactly one bus cycle. The data goes straight from one side to the other and the channel never stores it. A direction bit picks either a memory write with acknowledge or a memory read with acknowledge. Each address can be held, incremented or decremented by the access size (1, 2 or 4 bytes).

Top module: `dma_sd_engine`

## Requirements
- R1: After reset the channel is idle: no read, write or acknowledge strobe, the end-of-transfer pulse is low, and done and the error flag are clear.
- R2: In dual mode (control bit 1 = 0), each unit is one read cycle driving the source address, then, in the very next cycle, one write cycle driving the destination address. The write cycle drives the data returned in the read cycle and enables the data output. The acknowledge strobe stays low.
- R3: After each unit, an address whose update field is 1 increases by the access size, one whose field is 2 decreases by it, and one whose field is 0 or 3 stays fixed. Addresses wrap modulo 2^AW. The source update field is control bits [6:5] and the destination update field is bits [8:7]. The size field is bits [4:3], coded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R4: In single mode (control bit 1 = 1), each unit takes one bus cycle. In that cycle the acknowledge strobe is high and the bus address is the source pointer. The destination register is not used.
- R5: In single mode, control bit 2 = 1 (device to memory) asserts the write strobe with acknowledge, and bit 2 = 0 asserts the read strobe with acknowledge. In both cases the channel never enables its data output.
- R6: A start request is refused if the unit count is zero, if the size code is 3, or if single mode is requested with a size other than the bus width. A refused start sets the error flag and runs no bus cycle.
- R7: Exactly as many units run as the count register holds. The end-of-transfer output is high only during the bus cycle that completes the last unit. In the next cycle the channel is idle and done is set.
- R8: Configuration writes made while the channel is active have no effect on the transfer in progress.
- R9: An accepted start clears both done and the error flag before the first bus cycle. Register select codes: 0 source, 1 destination, 2 count, 3 control. Control bit 0 is start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select (0 src, 1 dst, 2 count, 3 control) |
| cfg_wdata | input | 32 | Configuration write data |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| dack | output | 1 | Peripheral acknowledge strobe (single mode) |
| bus_wdata | output | DW | Write data driven by the channel |
| bus_wdata_oe | output | 1 | Data output enable |
| bus_rdata | input | DW | Data returned on the bus |
| tend | output | 1 | High during the final unit's bus cycle |
| busy | output | 1 | Channel active |
| done | output | 1 | Set on completion, cleared on start |
| cfg_err | output | 1 | Last start request was refused |

## Verification
The hardest case to reach from the ports is a configuration write that arrives while a transfer is running. The write has to land inside the short window between the start and the final unit, and the only evidence that it was ignored is the addresses the bus carries afterwards. The bench therefore drives a source-register write in the first active cycle of a multi-unit dual transfer and keeps checking the addresses against the original pointer arithmetic. Refused starts are reached by combining single mode with a size narrower than the bus, an invalid size code, and a zero count. In each case the bench checks that no strobe appears and that the next accepted start clears the flag.

// File: rtl/dma_sd_pkg.sv
package dma_sd_pkg;

    localparam logic [1:0] REG_SRC  = 2'd0;
    localparam logic [1:0] REG_DST  = 2'd1;
    localparam logic [1:0] REG_CNT  = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    localparam logic [1:0] UPD_HOLD = 2'd0;
    localparam logic [1:0] UPD_INC  = 2'd1;
    localparam logic [1:0] UPD_DEC  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_SINGLE = 2'd3
    } dma_state_e;

    typedef struct packed {
        logic [1:0] dst_upd;
        logic [1:0] src_upd;
        logic [1:0] size;
        logic       dev_to_mem;
        logic       single;
    } chan_ctrl_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_sd_regs.sv
module dma_sd_regs
    import dma_sd_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter logic [1:0] BUS_SZ = 2'd2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          busy,
    input  logic          step,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] cnt_left,
    output logic          dev_to_mem,
    output logic          launch,
    output logic          launch_single,
    output logic          cfg_err
);

    chan_ctrl_t ctrl_q;
    chan_ctrl_t new_ctrl;
    logic       wr_ok;
    logic       start_req;
    logic       bad_cfg;

    assign new_ctrl  = chan_ctrl_t'(cfg_wdata[8:1]);
    assign wr_ok     = cfg_we && !busy;
    assign start_req = wr_ok && (cfg_sel == REG_CTRL) && cfg_wdata[0];
    assign bad_cfg   = (new_ctrl.size == 2'd3) || (cnt_left == '0) ||
                       (new_ctrl.single && (new_ctrl.size != BUS_SZ));
    assign launch        = start_req && !bad_cfg;
    assign launch_single = new_ctrl.single;
    assign dev_to_mem    = ctrl_q.dev_to_mem;

    function automatic logic [AW-1:0] move(input logic [AW-1:0] a,
                                           input logic [1:0]    upd,
                                           input logic [1:0]    sz);
        logic [AW-1:0] d;
        d = AW'(size_bytes(sz));
        case (upd)
            UPD_INC: return a + d;
            UPD_DEC: return a - d;
            default: return a;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            src_ptr  <= '0;
            dst_ptr  <= '0;
            cnt_left <= '0;
            ctrl_q   <= '0;
            cfg_err  <= 1'b0;
        end else if (wr_ok) begin
            case (cfg_sel)
                REG_SRC: src_ptr  <= cfg_wdata[AW-1:0];
                REG_DST: dst_ptr  <= cfg_wdata[AW-1:0];
                REG_CNT: cnt_left <= cfg_wdata[CW-1:0];
                default: ctrl_q   <= new_ctrl;
            endcase
            if (start_req) cfg_err <= bad_cfg;
        end else if (step) begin
            cnt_left <= cnt_left - CW'(1);
            src_ptr  <= move(src_ptr, ctrl_q.src_upd, ctrl_q.size);
            if (!ctrl_q.single)
                dst_ptr <= move(dst_ptr, ctrl_q.dst_upd, ctrl_q.size);
        end
    end

endmodule

// File: rtl/dma_sd_seq.sv
module dma_sd_seq
    import dma_sd_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          launch_single,
    input  logic [CW-1:0] cnt_left,
    output dma_state_e    state,
    output logic          step,
    output logic          last,
    output logic          done
);

    dma_state_e state_n;

    assign step = (state == ST_WRITE) || (state == ST_SINGLE);
    assign last = step && (cnt_left == CW'(1));

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:   if (launch) state_n = launch_single ? ST_SINGLE : ST_READ;
            ST_READ:   state_n = ST_WRITE;
            ST_WRITE:  state_n = last ? ST_IDLE : ST_READ;
            ST_SINGLE: state_n = last ? ST_IDLE : ST_SINGLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_n;
            if (launch)    done <= 1'b0;
            else if (last) done <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_sd_busdrv.sv
module dma_sd_busdrv
    import dma_sd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  dma_state_e    state,
    input  logic [AW-1:0] src_ptr,
    input  logic [AW-1:0] dst_ptr,
    input  logic          dev_to_mem,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          dack,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe
);

    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)                   hold_q <= '0;
        else if (state == ST_READ) hold_q <= bus_rdata;
    end

    always_comb begin
        bus_addr     = '0;
        bus_rd       = 1'b0;
        bus_wr       = 1'b0;
        dack         = 1'b0;
        bus_wdata    = '0;
        bus_wdata_oe = 1'b0;
        case (state)
            ST_READ: begin
                bus_addr = src_ptr;
                bus_rd   = 1'b1;
            end
            ST_WRITE: begin
                bus_addr     = dst_ptr;
                bus_wr       = 1'b1;
                bus_wdata    = hold_q;
                bus_wdata_oe = 1'b1;
            end
            ST_SINGLE: begin
                bus_addr = src_ptr;
                dack     = 1'b1;
                bus_wr   = dev_to_mem;
                bus_rd   = !dev_to_mem;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_sd_engine.sv
module dma_sd_engine
    import dma_sd_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int BUS_BYTES = 4,
    localparam int DW       = 8 * BUS_BYTES,
    localparam logic [1:0] BUS_SZ = 2'($clog2(BUS_BYTES))
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          dack,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe,
    input  logic [DW-1:0] bus_rdata,
    output logic          tend,
    output logic          busy,
    output logic          done,
    output logic          cfg_err
);

    logic [AW-1:0] src_ptr;
    logic [AW-1:0] dst_ptr;
    logic [CW-1:0] cnt_left;
    logic          dev_to_mem;
    logic          launch;
    logic          launch_single;
    logic          step;
    logic          last;
    dma_state_e    state;

    assign busy = (state != ST_IDLE);
    assign tend = last;

    dma_sd_regs #(.AW(AW), .CW(CW), .BUS_SZ(BUS_SZ)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .step(step),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt_left(cnt_left),
        .dev_to_mem(dev_to_mem), .launch(launch),
        .launch_single(launch_single), .cfg_err(cfg_err)
    );

    dma_sd_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst(rst), .launch(launch), .launch_single(launch_single),
        .cnt_left(cnt_left), .state(state), .step(step), .last(last),
        .done(done)
    );

    dma_sd_busdrv #(.AW(AW), .DW(DW)) u_bus (
        .clk(clk), .rst(rst), .state(state), .src_ptr(src_ptr),
        .dst_ptr(dst_ptr), .dev_to_mem(dev_to_mem), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .dack(dack),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe)
    );

endmodule

// File: rtl/dma_sd_checker.sv
module dma_sd_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          cfg_err,
    input logic          tend,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          dack,
    input logic          bus_wdata_oe,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_rd && !bus_wr && !dack && !tend));

    p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !dack) |=> (bus_wr && !dack && bus_wdata_oe));

    p_wdata_from_read_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !dack) |-> (bus_wdata == $past(bus_rdata)));

    p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        dack |-> (($countones({bus_rd, bus_wr}) == 1) && !bus_wdata_oe));

    p_tend_then_done_r7: assert property (@(posedge clk) disable iff (rst)
        tend |=> (done && !busy));

    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!cfg_err && !done));

endmodule

bind dma_sd_engine dma_sd_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .cfg_err(cfg_err),
    .tend(tend), .bus_rd(bus_rd), .bus_wr(bus_wr), .dack(dack),
    .bus_wdata_oe(bus_wdata_oe), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/dma_sd_engine_tb.sv
module dma_sd_engine_tb;

    localparam logic [31:0] KEY = 32'h5A3C_96E1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] bus_addr;
    logic        bus_rd, bus_wr, dack, bus_wdata_oe, tend, busy, done, cfg_err;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    int          checks = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    assign bus_rdata = bus_addr ^ KEY;

    dma_sd_engine u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .dack(dack), .bus_wdata(bus_wdata),
        .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata), .tend(tend),
        .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input int single, input int dir,
            input int size, input int su, input int du);
        return 32'((du << 7) | (su << 5) | (size << 3) | (dir << 2) | (single << 1) | 1);
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] a, input int upd, input int size);
        logic [31:0] d;
        d = 32'(1 << size);
        if (upd == 1) return a + d;
        if (upd == 2) return a - d;
        return a;
    endfunction

    task automatic run(input int single, input int dir, input int size, input int su,
            input int du, input int cnt, input logic [31:0] s0, input logic [31:0] d0,
            input int meddle);
        logic [31:0] es, ed;
        string ra;
        es = s0; ed = d0;
        ra = meddle ? "R8" : "R3";
        cfg(2'd0, s0); cfg(2'd1, d0); cfg(2'd2, 32'(cnt));
        cfg(2'd3, ctrl_word(single, dir, size, su, du));
        check("R9 done cleared", 32'(done), 32'd0);
        check("R9 err cleared", 32'(cfg_err), 32'd0);
        for (int i = 0; i < cnt; i++) begin
            if (meddle != 0 && i == 0) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h7777_0000;
            end
            if (single == 0) begin
                check("R2 rd", {29'd0, bus_rd, bus_wr, dack}, 32'b100);
                check({ra, " src addr"}, bus_addr, es);
                check("R7 tend low on read", 32'(tend), 32'd0);
                @(negedge clk); cfg_we = 1'b0;
                check("R2 wr", {29'd0, bus_rd, bus_wr, dack}, 32'b010);
                check({ra, " dst addr"}, bus_addr, ed);
                check("R2 wdata", bus_wdata, es ^ KEY);
                check("R2 oe", 32'(bus_wdata_oe), 32'd1);
                check("R7 tend", 32'(tend), 32'(i == cnt - 1));
                es = adv(es, su, size); ed = adv(ed, du, size);
                @(negedge clk);
            end else begin
                check("R4 dack", 32'(dack), 32'd1);
                check("R4 addr", bus_addr, es);
                check("R5 strobes", {30'd0, bus_rd, bus_wr}, dir != 0 ? 32'b01 : 32'b10);
                check("R5 no oe", 32'(bus_wdata_oe), 32'd0);
                check("R7 tend", 32'(tend), 32'(i == cnt - 1));
                es = adv(es, su, size);
                @(negedge clk); cfg_we = 1'b0;
            end
        end
        check("R7 idle after", 32'(busy), 32'd0);
        check("R7 done", 32'(done), 32'd1);
    endtask

    task automatic refused(input logic [31:0] c, input logic [31:0] ctl);
        cfg(2'd2, c);
        cfg(2'd3, ctl);
        check("R6 err set", 32'(cfg_err), 32'd1);
        check("R6 not busy", 32'(busy), 32'd0);
        check("R6 no strobe", {29'd0, bus_rd, bus_wr, dack}, 32'd0);
        @(negedge clk);
        check("R6 still idle", {28'd0, busy, bus_rd, bus_wr, dack}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 flags", {30'd0, done, cfg_err}, 32'd0);
        check("R1 strobes", {28'd0, bus_rd, bus_wr, dack, tend}, 32'd0);

        run(0, 0, 2, 1, 0, 3, 32'h0000_1000, 32'h0000_2000, 0);
        refused(32'd1, ctrl_word(1, 1, 0, 1, 0));
        refused(32'd1, ctrl_word(1, 0, 1, 1, 0));
        refused(32'd2, ctrl_word(0, 0, 3, 1, 1));
        refused(32'd0, ctrl_word(0, 0, 2, 1, 1));
        run(0, 0, 1, 1, 1, 2, 32'h0000_0400, 32'h0000_0800, 0);
        run(0, 0, 2, 1, 0, 3, 32'h0000_3000, 32'h0000_5000, 1);

        for (int sz = 0; sz < 3; sz++)
            for (int su = 0; su < 4; su++)
                for (int du = 0; du < 4; du++)
                    for (int c = 1; c < 3; c++)
                        run(0, 0, sz, su, du, c,
                            (su == 1) ? 32'hFFFF_FFFC : 32'h0000_0002,
                            (du == 2) ? 32'h0000_0001 : 32'h8000_0100, 0);

        for (int dir = 0; dir < 2; dir++)
            for (int su = 0; su < 4; su++)
                for (int c = 1; c < 4; c++)
                    run(1, dir, 2, su, 0, c,
                        (su == 1) ? 32'hFFFF_FFF8 : 32'h0000_0004, 32'h1234_5678, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule